// File: doc/BRIEF.md
# Dual-Channel Serial Interrupt Prioritizer

This block keeps the interrupt bookkeeping for a serial controller with two channels, called A and B. For each channel it tracks four flags: receive pending, transmit pending, receive under service and transmit under service. It also tracks the receive-available status.

Its inputs are event strobes and control bits. The strobes report a received byte arriving, a write to the transmit buffer, a read of the data register, and a command issued through the command register. The control bits are the transmit-interrupt enable, the receive interrupt mode, the break enable, the break status and the status-high vector placement.

From these it keeps three outputs up to date:
- a six-bit pending register;
- an eight-bit modified vector, which names the source most recently raised or cleared;
- one registered interrupt line, which is the OR of both channels' requests.

A receive interrupt under service holds off transmit interrupts. The transmit interrupt is raised again when the host sends the reset-highest-under-service command.

Channel index 0 is channel B and index 1 is channel A on every two-bit port.

Top module: `sio_irq_prio`

## Requirements
- R1: After reset, irq is 0, pendBits is 0x00, vector is 0x00 and rxAvail is 0.
- R2: A rxArrive strobe does the following for its channel:
  - sets rxAvail;
  - sets receive pending and receive under service;
  - sets the channel's receive pending bit (A: bit 5, B: bit 2);
  - loads the vector with that channel's receive code.
- R3: A txWrite strobe drops and then raises transmit pending. When receive is not under service on that channel, it also:
  - sets transmit under service;
  - sets the transmit pending bit (A: bit 4, B: bit 1), but only if txIntEn for that channel is 1;
  - loads the vector with the channel's transmit code.
  When receive is under service, pendBits and vector are left unchanged.
- R4: A dataRead strobe does the following, in this order:
  - clears rxAvail, receive pending and receive under service;
  - clears the receive pending bit;
  - loads the no-interrupt vector;
  - if transmit is still pending, raises it again as in R3.
- R5: Command code 3'b101 does the following, in this order:
  - clears transmit pending, transmit under service and the transmit pending bit;
  - loads the no-interrupt vector;
  - if receive is still pending, raises it again as in R2.
- R6: Command code 3'b111 acts on the under-service flags. If receive is under service, it clears that flag and, when transmit is pending, raises transmit as in R3. Otherwise it clears transmit under service and leaves pendBits and vector unchanged. The other command codes have no effect.
- R7: With statusHigh=0 the vector codes are:
  - no interrupt: 0x06
  - A receive: 0x0C
  - B receive: 0x04
  - A transmit: 0x08
  - B transmit: 0x00

  With statusHigh=1 they are 0x60, 0x30, 0x20 and 0x10 in the same order, and B transmit stays 0x00. The placement is taken from statusHigh at the moment the vector loads.
- R8: A channel requests an interrupt when any of these holds:
  - txIntEn=1 and transmit is pending;
  - its rxMode field is 2'b01 or 2'b10 and receive is pending;
  - brkIntEn=1 and brkStat=1.

  irq is the OR of both channels' requests, registered, so it shows the flags one clock after they change.
- R9: pendBits bits 0 and 3 always read 0.
- R10: Events in the same cycle are applied in a fixed order. Within a channel the order is arrive, read, write, command. Channel B is applied before channel A, so the later event decides the vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxArrive | input | 2 | Received byte arrived, per channel |
| txWrite | input | 2 | Transmit buffer written, per channel |
| dataRead | input | 2 | Data register read, per channel |
| cmdStrobe | input | 2 | Command issued, per channel |
| cmdCode | input | 3 | Command code for cmdStrobe |
| txIntEn | input | 2 | Transmit interrupt enable, per channel |
| rxMode | input | 4 | Receive interrupt mode; [1:0] B, [3:2] A |
| brkIntEn | input | 2 | Break interrupt enable, per channel |
| brkStat | input | 2 | Break status, per channel |
| statusHigh | input | 1 | Selects high placement of vector codes |
| irq | output | 1 | Registered interrupt request |
| pendBits | output | 6 | Pending register |
| vector | output | 8 | Modified interrupt vector |
| rxAvail | output | 2 | Receive character available, per channel |

## Verification
The bench targets the hold-off path. It raises a transmit interrupt while a receive interrupt on the same channel is under service, and checks that neither the vector nor the transmit pending bit moves until the 3'b111 command releases it. A design without the hold-off would show 0x08 too early; one that forgets to re-raise would stay at 0x0C. It also checks that clearing one source brings back the other one that is still pending, and that 3'b111 without receive under service leaves the vector alone. Further cases are the rxMode value 2'b11 that does not request, an irq that rises when txIntEn turns on with transmit already pending, the status-high codes including the fixed B transmit code, and events on both channels in one cycle, where the wrong order would leave the other channel's vector.

// File: rtl/sio_irq_pkg.sv
package sio_irq_pkg;
  localparam int NUM_CH = 2;
  localparam int VEC_W  = 8;
  localparam int CMD_W  = 3;
  localparam int PEND_W = 3 * NUM_CH;

  localparam logic [CMD_W-1:0] CMD_CLR_TX  = 3'b101;
  localparam logic [CMD_W-1:0] CMD_RST_IUS = 3'b111;

  typedef enum logic [2:0] {
    SRC_NONE, SRC_BRX, SRC_ARX, SRC_BTX, SRC_ATX
  } vecSrc_e;

  typedef struct packed {
    logic              vecLoad;
    vecSrc_e           vecSrc;
    logic [PEND_W-1:0] pendWr;
    logic [PEND_W-1:0] pendVal;
    logic              reqAny;
  } ctlStrobe_t;
endpackage

// File: rtl/sio_irq_ctl.sv
module sio_irq_ctl
  import sio_irq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_CH-1:0]    rxArrive,
  input  logic [NUM_CH-1:0]    txWrite,
  input  logic [NUM_CH-1:0]    dataRead,
  input  logic [NUM_CH-1:0]    cmdStrobe,
  input  logic [CMD_W-1:0]     cmdCode,
  input  logic [NUM_CH-1:0]    txIntEn,
  input  logic [2*NUM_CH-1:0]  rxMode,
  input  logic [NUM_CH-1:0]    brkIntEn,
  input  logic [NUM_CH-1:0]    brkStat,
  output logic [NUM_CH-1:0]    rxAvail,
  output ctlStrobe_t           stb
);
  logic [NUM_CH-1:0] rxPend, txPend, rxSvc, txSvc;
  logic [NUM_CH-1:0] rxPendN, txPendN, rxSvcN, txSvcN, rxAvailN;
  logic [NUM_CH-1:0] chReq;

  always_comb begin
    rxPendN = rxPend;
    txPendN = txPend;
    rxSvcN  = rxSvc;
    txSvcN  = txSvc;
    rxAvailN = rxAvail;
    stb.vecLoad = 1'b0;
    stb.vecSrc  = SRC_NONE;
    stb.pendWr  = '0;
    stb.pendVal = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      // receive bit / transmit bit of this channel in the pending register
      automatic int rxBit = 3 * c + 2;
      automatic int txBit = 3 * c + 1;
      automatic vecSrc_e rxSrc = (c == 1) ? SRC_ARX : SRC_BRX;
      automatic vecSrc_e txSrc = (c == 1) ? SRC_ATX : SRC_BTX;
      if (rxArrive[c]) begin
        rxAvailN[c] = 1'b1;
        rxPendN[c] = 1'b1; rxSvcN[c] = 1'b1;
        stb.pendWr[rxBit] = 1'b1; stb.pendVal[rxBit] = 1'b1;
        stb.vecLoad = 1'b1; stb.vecSrc = rxSrc;
      end
      if (dataRead[c]) begin
        rxAvailN[c] = 1'b0;
        rxPendN[c] = 1'b0; rxSvcN[c] = 1'b0;
        stb.pendWr[rxBit] = 1'b1; stb.pendVal[rxBit] = 1'b0;
        stb.vecLoad = 1'b1; stb.vecSrc = SRC_NONE;
        if (txPendN[c]) begin
          txSvcN[c] = 1'b1;
          if (txIntEn[c]) begin
            stb.pendWr[txBit] = 1'b1; stb.pendVal[txBit] = 1'b1;
          end
          stb.vecSrc = txSrc;
        end
      end
      if (txWrite[c]) begin
        txPendN[c] = 1'b1;
        if (!rxSvcN[c]) begin
          txSvcN[c] = 1'b1;
          if (txIntEn[c]) begin
            stb.pendWr[txBit] = 1'b1; stb.pendVal[txBit] = 1'b1;
          end
          stb.vecLoad = 1'b1; stb.vecSrc = txSrc;
        end
      end
      if (cmdStrobe[c] && cmdCode == CMD_CLR_TX) begin
        txPendN[c] = 1'b0; txSvcN[c] = 1'b0;
        stb.pendWr[txBit] = 1'b1; stb.pendVal[txBit] = 1'b0;
        stb.vecLoad = 1'b1; stb.vecSrc = SRC_NONE;
        if (rxPendN[c]) begin
          rxSvcN[c] = 1'b1;
          stb.pendWr[rxBit] = 1'b1; stb.pendVal[rxBit] = 1'b1;
          stb.vecSrc = rxSrc;
        end
      end
      if (cmdStrobe[c] && cmdCode == CMD_RST_IUS) begin
        if (rxSvcN[c]) begin
          rxSvcN[c] = 1'b0;
          if (txPendN[c]) begin
            txSvcN[c] = 1'b1;
            if (txIntEn[c]) begin
              stb.pendWr[txBit] = 1'b1; stb.pendVal[txBit] = 1'b1;
            end
            stb.vecLoad = 1'b1; stb.vecSrc = txSrc;
          end
        end else begin
          txSvcN[c] = 1'b0;
        end
      end
    end
  end

  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : gReq
      logic [1:0] mode;
      assign mode = rxMode[2*g +: 2];
      assign chReq[g] = (txIntEn[g] && txPend[g]) ||
                        ((mode == 2'b01 || mode == 2'b10) && rxPend[g]) ||
                        (brkIntEn[g] && brkStat[g]);
    end
  endgenerate
  assign stb.reqAny = |chReq;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxPend <= '0; txPend <= '0; rxSvc <= '0; txSvc <= '0; rxAvail <= '0;
    end else begin
      rxPend <= rxPendN; txPend <= txPendN;
      rxSvc  <= rxSvcN;  txSvc  <= txSvcN;
      rxAvail <= rxAvailN;
    end
  end

  a_r2_svc_implies_pend: assert property (@(posedge clk) disable iff (!rstN)
    ((rxSvc & ~rxPend) == '0));
  a_r4_read_clears_avail: assert property (@(posedge clk) disable iff (!rstN)
    (dataRead[0] && !rxArrive[0]) |=> !rxAvail[0]);
  a_r3_write_raises_tx: assert property (@(posedge clk) disable iff (!rstN)
    (txWrite[1] && !cmdStrobe[1]) |=> txPend[1]);
endmodule

// File: rtl/sio_irq_dp.sv
module sio_irq_dp
  import sio_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        stb,
  input  logic              statusHigh,
  output logic              irq,
  output logic [PEND_W-1:0] pendBits,
  output logic [VEC_W-1:0]  vector
);
  logic [VEC_W-1:0] vecCode;

  always_comb begin
    unique case (stb.vecSrc)
      SRC_BRX: vecCode = statusHigh ? 8'h20 : 8'h04;
      SRC_ARX: vecCode = statusHigh ? 8'h30 : 8'h0C;
      SRC_BTX: vecCode = 8'h00;
      SRC_ATX: vecCode = statusHigh ? 8'h10 : 8'h08;
      default: vecCode = statusHigh ? 8'h60 : 8'h06;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irq <= 1'b0;
      pendBits <= '0;
      vector <= '0;
    end else begin
      irq <= stb.reqAny;
      pendBits <= (pendBits & ~stb.pendWr) | (stb.pendVal & stb.pendWr);
      if (stb.vecLoad) vector <= vecCode;
    end
  end

  a_r8_irq_lags_request: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (irq == $past(stb.reqAny)));
  a_r9_ext_bits_zero: assert property (@(posedge clk) disable iff (!rstN)
    (pendBits[0] == 1'b0) && (pendBits[3] == 1'b0));
  a_r7_vector_legal: assert property (@(posedge clk) disable iff (!rstN)
    vector inside {8'h00, 8'h04, 8'h06, 8'h08, 8'h0C,
                   8'h10, 8'h20, 8'h30, 8'h60});
endmodule

// File: rtl/sio_irq_prio.sv
module sio_irq_prio
  import sio_irq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  rxArrive,
  input  logic [1:0]  txWrite,
  input  logic [1:0]  dataRead,
  input  logic [1:0]  cmdStrobe,
  input  logic [2:0]  cmdCode,
  input  logic [1:0]  txIntEn,
  input  logic [3:0]  rxMode,
  input  logic [1:0]  brkIntEn,
  input  logic [1:0]  brkStat,
  input  logic        statusHigh,
  output logic        irq,
  output logic [5:0]  pendBits,
  output logic [7:0]  vector,
  output logic [1:0]  rxAvail
);
  ctlStrobe_t stb;

  sio_irq_ctl u_ctl (
    .clk(clk), .rstN(rstN), .rxArrive(rxArrive), .txWrite(txWrite),
    .dataRead(dataRead), .cmdStrobe(cmdStrobe), .cmdCode(cmdCode),
    .txIntEn(txIntEn), .rxMode(rxMode), .brkIntEn(brkIntEn),
    .brkStat(brkStat), .rxAvail(rxAvail), .stb(stb)
  );

  sio_irq_dp u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .statusHigh(statusHigh),
    .irq(irq), .pendBits(pendBits), .vector(vector)
  );

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rstN |=> (irq == 1'b0 && pendBits == '0 && rxAvail == '0));
endmodule

// File: tb/sim_sio_irq_prio.sv
module sim_sio_irq_prio;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] rxArrive = '0, txWrite = '0, dataRead = '0, cmdStrobe = '0;
  logic [2:0] cmdCode = '0;
  logic [1:0] txIntEn = '0, brkIntEn = '0, brkStat = '0;
  logic [3:0] rxMode = '0;
  logic statusHigh = 1'b0;
  logic irq;
  logic [5:0] pendBits;
  logic [7:0] vector;
  logic [1:0] rxAvail;
  int nChk = 0, nFail = 0;

  always #10 clk = ~clk;

  sio_irq_prio u0 (.*);

  task automatic chk(input string req, input int got, input int exp);
    nChk++;
    if (got != exp) begin
      nFail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    rxArrive = '0; txWrite = '0; dataRead = '0; cmdStrobe = '0; cmdCode = '0;
    txIntEn = '0; brkIntEn = '0; brkStat = '0; rxMode = '0; statusHigh = 1'b0;
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
  endtask

  // one event pulse covering one rising edge; returns at the next falling edge
  task automatic pulse(input logic [1:0] ra, input logic [1:0] tw,
                       input logic [1:0] dr, input logic [1:0] cs,
                       input logic [2:0] code);
    rxArrive = ra; txWrite = tw; dataRead = dr; cmdStrobe = cs; cmdCode = code;
    @(negedge clk);
    rxArrive = '0; txWrite = '0; dataRead = '0; cmdStrobe = '0;
  endtask

  task automatic tReset();
    doReset();
    chk("R1 irq", irq, 0); chk("R1 pend", pendBits, 0);
    chk("R1 vector", vector, 8'h00); chk("R1 rxAvail", rxAvail, 0);
  endtask

  task automatic tRxB();
    doReset(); rxMode = 4'b0001;
    pulse(2'b01, 0, 0, 0, 0);
    chk("R2 pend", pendBits, 6'h04); chk("R2 vector", vector, 8'h04);
    chk("R2 rxAvail", rxAvail, 2'b01);
    @(negedge clk); chk("R8 irq rx", irq, 1);
    pulse(0, 0, 2'b01, 0, 0);
    chk("R4 pend", pendBits, 0); chk("R4 vector", vector, 8'h06);
    chk("R4 rxAvail", rxAvail, 0);
    @(negedge clk); chk("R8 irq drop", irq, 0);
  endtask

  task automatic tTxA();
    doReset(); txIntEn = 2'b10;
    pulse(0, 2'b10, 0, 0, 0);
    chk("R3 pend", pendBits, 6'h10); chk("R3 vector", vector, 8'h08);
    @(negedge clk); chk("R8 irq tx", irq, 1);
    pulse(0, 0, 0, 2'b10, 3'b101);
    chk("R5 pend", pendBits, 0); chk("R5 vector", vector, 8'h06);
    @(negedge clk); chk("R5 irq", irq, 0);
  endtask

  task automatic tHoldOff();
    doReset(); rxMode = 4'b0100; txIntEn = 2'b10;
    pulse(2'b10, 0, 0, 0, 0);
    chk("R2 A vector", vector, 8'h0C); chk("R2 A pend", pendBits, 6'h20);
    pulse(0, 2'b10, 0, 0, 0);
    chk("R3 held vector", vector, 8'h0C); chk("R3 held pend", pendBits, 6'h20);
    pulse(0, 0, 0, 2'b10, 3'b111);
    chk("R6 release vector", vector, 8'h08); chk("R6 release pend", pendBits, 6'h30);
    pulse(0, 0, 0, 2'b10, 3'b101);
    chk("R5 reraise rx vector", vector, 8'h0C); chk("R5 reraise pend", pendBits, 6'h20);
    pulse(0, 0, 2'b10, 0, 0);
    chk("R4 vector", vector, 8'h06); chk("R4 pend", pendBits, 0);
    @(negedge clk); chk("R8 irq idle", irq, 0);
  endtask

  task automatic tIusNoRx();
    doReset(); txIntEn = 2'b10;
    pulse(0, 2'b10, 0, 0, 0);
    pulse(0, 0, 0, 2'b10, 3'b111);
    chk("R6 no-rx vector", vector, 8'h08); chk("R6 no-rx pend", pendBits, 6'h10);
    pulse(0, 0, 0, 2'b10, 3'b010);
    chk("R6 other code vector", vector, 8'h08); chk("R6 other code pend", pendBits, 6'h10);
    @(negedge clk); chk("R6 irq kept", irq, 1);
  endtask

  task automatic tGating();
    doReset();
    pulse(0, 2'b01, 0, 0, 0);
    chk("R3 disabled pend", pendBits, 0);
    @(negedge clk); chk("R8 tx disabled", irq, 0);
    txIntEn = 2'b01;
    @(negedge clk); @(negedge clk); chk("R8 tx enable late", irq, 1);
    rxMode = 4'b0011;
    pulse(2'b01, 0, 0, 0, 0);
    txIntEn = 2'b00;
    @(negedge clk); @(negedge clk); chk("R8 mode 11 no req", irq, 0);
    rxMode = 4'b0010;
    @(negedge clk); @(negedge clk); chk("R8 mode 10 req", irq, 1);
  endtask

  task automatic tBreak();
    doReset(); brkStat = 2'b10;
    @(negedge clk); @(negedge clk); chk("R8 brk disabled", irq, 0);
    brkIntEn = 2'b10;
    @(negedge clk); @(negedge clk); chk("R8 brk enabled", irq, 1);
    chk("R9 ext bits", pendBits & 6'h09, 0);
  endtask

  task automatic tHigh();
    doReset(); statusHigh = 1'b1; rxMode = 4'b0101; txIntEn = 2'b11;
    pulse(2'b10, 0, 0, 0, 0); chk("R7 A rx high", vector, 8'h30);
    pulse(2'b01, 0, 0, 0, 0); chk("R7 B rx high", vector, 8'h20);
    pulse(0, 0, 2'b01, 0, 0); chk("R7 none high", vector, 8'h60);
    pulse(0, 2'b01, 0, 0, 0); chk("R7 B tx high", vector, 8'h00);
    pulse(0, 0, 0, 2'b10, 3'b111);
    pulse(0, 2'b10, 0, 0, 0); chk("R7 A tx high", vector, 8'h10);
  endtask

  task automatic tOrder();
    doReset(); rxMode = 4'b0101;
    pulse(2'b11, 0, 0, 0, 0);
    chk("R10 both vector", vector, 8'h0C); chk("R10 both pend", pendBits, 6'h24);
    doReset();
    pulse(2'b01, 0, 2'b01, 0, 0);
    chk("R10 arrive-read avail", rxAvail, 0); chk("R10 arrive-read vector", vector, 8'h06);
  endtask

  initial begin
    fork
      begin
        tReset(); tRxB(); tTxA(); tHoldOff(); tIusNoRx();
        tGating(); tBreak(); tHigh(); tOrder();
      end
      begin
        repeat (20000) @(posedge clk);
        nChk++; nFail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule